// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

The block links one host-side port (A) with two memory-side ports (P1 and P2). Each port is 12 bits wide by default. Four gated, level-sensitive storage stages move data between them. Two stages carry A toward P1 and toward P2. The other two carry P1 and P2 back toward A. A select input picks which return stage drives A.

Because the A-side stages open independently, successive host words can be captured into P1 (the even bank) and P2 (the odd bank) for interleaved writes. Either bank can also be read back through the single return path.

Each bidirectional pin group appears as three signals: an input vector, an output vector, and a drive-enable output. Each port has its own active-low output enable. Each port also has an input-valid flag. While that flag is low, a bus-hold keeper supplies the last value the outside world drove on that port.

The design is clocked. While a stage's enable is high, its output follows its input combinationally. The stored copy is updated at every rising clock edge while the enable is high. Once the enable is low, the stage presents the value captured at the last rising edge where the enable was high.

Top module: `xbar_exchanger`

## Requirements
- R1: While le_a_to_p1 (or le_a_to_p2) is high, p1_out (or p2_out) equals the effective A input in the same cycle, with no clock delay.
- R2: While le_p1_to_a (or le_p2_to_a) is high and that return stage is selected, a_out equals the effective P1 (or P2) input in the same cycle.
- R3: While a stage's enable is low, its output stays at the value sampled at the last rising clock edge where that enable was high, whatever its input does.
- R4: When sel_p1 is 1, a_out shows the P1-to-A stage. When sel_p1 is 0, a_out shows the P2-to-A stage. This holds for both transparent and held values.
- R5: The drive enables are active low. Each drive-enable output (a_drv, p1_drv, p2_drv) is 1 exactly when its oe_*_n input is 0.
- R6: oe_p1_n and oe_p2_n act independently. All four combinations produce the matching {p1_drv, p2_drv} pattern.
- R7: With both A-side enables high, one A value reaches P1 and P2 in the same cycle, and both stages then hold it.
- R8: When a port's input-valid flag is low, the effective input of that port is the value it carried at the last rising edge where the flag was high. A keeper never changes while its flag is low.
- R9: While rst_n is low (asserted asynchronously, released through a two-stage synchronizer), all four stored copies and all three keepers read zero. With all enables low, every data output then reads 0.
- R10: Successive A values captured by alternating le_a_to_p1 and le_a_to_p2 remain held on P1 and P2 at the same time (interleaved write).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | Data arriving on host port A |
| a_in_vld | input | 1 | Port A is externally driven |
| a_out | output | W | Return-path data for port A |
| a_drv | output | 1 | Port A is being driven |
| p1_in | input | W | Data arriving on even-bank port P1 |
| p1_in_vld | input | 1 | Port P1 is externally driven |
| p1_out | output | W | A-to-P1 stage output |
| p1_drv | output | 1 | Port P1 is being driven |
| p2_in | input | W | Data arriving on odd-bank port P2 |
| p2_in_vld | input | 1 | Port P2 is externally driven |
| p2_out | output | W | A-to-P2 stage output |
| p2_drv | output | 1 | Port P2 is being driven |
| le_a_to_p1 | input | 1 | Opens the A-to-P1 stage |
| le_a_to_p2 | input | 1 | Opens the A-to-P2 stage |
| le_p1_to_a | input | 1 | Opens the P1-to-A stage |
| le_p2_to_a | input | 1 | Opens the P2-to-A stage |
| sel_p1 | input | 1 | 1 selects P1 return, 0 selects P2 return |
| oe_a_n | input | 1 | Active-low output enable, port A |
| oe_p1_n | input | 1 | Active-low output enable, port P1 |
| oe_p2_n | input | 1 | Active-low output enable, port P2 |

## Verification
Transparent results (R1, R2, R4 with an open stage, R5, R6) take no cycles: they are due in the cycle in which the stimulus is applied. Held results (R3, R7, R8, R10) reflect the input present at the previous rising edge, so they are due exactly one edge after the last cycle with the enable or valid flag high.

The bench drives each vector just after a falling edge and samples 1 ns later, before the next rising edge. Every expected value is therefore the combinational response to the current vector, combined with the state committed at the edge that ended the previous vector. The reset checks are sampled while rst_n is low, and again after the synchronizer has released.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int XB_WIDTH   = 12;
  localparam int XB_BPORTS  = 2;
  localparam int XB_SYNC    = 2;
  typedef enum logic { RET_P2 = 1'b0, RET_P1 = 1'b1 } ret_sel_e;
endpackage

// File: rtl/xbar_keeper.sv
module xbar_keeper #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic [W-1:0] din,
  output logic [W-1:0] eff
);
  logic [W-1:0] keep_q, keep_d;

  always_comb begin
    keep_d = keep_q;
    if (vld) keep_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) keep_q <= '0;
    else        keep_q <= keep_d;
  end

  assign eff = vld ? din : keep_q;
endmodule

// File: rtl/xbar_stage.sv
module xbar_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held_q, held_d;

  always_comb begin
    held_d = held_q;
    if (open) held_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign q = open ? d : held_q;
endmodule

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xbar_exchanger.sv
module xbar_exchanger
  import xbar_pkg::*;
#(
  parameter int W = XB_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic         a_in_vld,
  output logic [W-1:0] a_out,
  output logic         a_drv,
  input  logic [W-1:0] p1_in,
  input  logic         p1_in_vld,
  output logic [W-1:0] p1_out,
  output logic         p1_drv,
  input  logic [W-1:0] p2_in,
  input  logic         p2_in_vld,
  output logic [W-1:0] p2_out,
  output logic         p2_drv,
  input  logic         le_a_to_p1,
  input  logic         le_a_to_p2,
  input  logic         le_p1_to_a,
  input  logic         le_p2_to_a,
  input  logic         sel_p1,
  input  logic         oe_a_n,
  input  logic         oe_p1_n,
  input  logic         oe_p2_n
);
  localparam int NB = XB_BPORTS;

  logic         rst_i_n;
  logic [W-1:0] a_eff;
  logic [W-1:0] b_in   [NB];
  logic         b_vld  [NB];
  logic [W-1:0] b_eff  [NB];
  logic         le_down[NB];
  logic         le_up  [NB];
  logic [W-1:0] down_q [NB];
  logic [W-1:0] up_q   [NB];
  ret_sel_e     ret_sel;

  xbar_rst_sync #(.STAGES(XB_SYNC)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  xbar_keeper #(.W(W)) u_keep_a (
    .clk(clk), .rst_n(rst_i_n), .vld(a_in_vld), .din(a_in), .eff(a_eff)
  );

  assign b_in[0]    = p1_in;
  assign b_in[1]    = p2_in;
  assign b_vld[0]   = p1_in_vld;
  assign b_vld[1]   = p2_in_vld;
  assign le_down[0] = le_a_to_p1;
  assign le_down[1] = le_a_to_p2;
  assign le_up[0]   = le_p1_to_a;
  assign le_up[1]   = le_p2_to_a;

  for (genvar g = 0; g < NB; g++) begin : g_bport
    xbar_keeper #(.W(W)) u_keep (
      .clk(clk), .rst_n(rst_i_n), .vld(b_vld[g]), .din(b_in[g]), .eff(b_eff[g])
    );
    xbar_stage #(.W(W)) u_down (
      .clk(clk), .rst_n(rst_i_n), .open(le_down[g]), .d(a_eff), .q(down_q[g])
    );
    xbar_stage #(.W(W)) u_up (
      .clk(clk), .rst_n(rst_i_n), .open(le_up[g]), .d(b_eff[g]), .q(up_q[g])
    );
  end

  assign ret_sel = ret_sel_e'(sel_p1);

  always_comb begin
    unique case (ret_sel)
      RET_P1:  a_out = up_q[0];
      default: a_out = up_q[1];
    endcase
  end

  assign p1_out = down_q[0];
  assign p2_out = down_q[1];
  assign a_drv  = ~oe_a_n;
  assign p1_drv = ~oe_p1_n;
  assign p2_drv = ~oe_p2_n;
endmodule

// File: rtl/xbar_exchanger_chk.sv
module xbar_exchanger_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic         a_in_vld,
  input logic [W-1:0] a_out,
  input logic         a_drv,
  input logic [W-1:0] p1_in,
  input logic         p1_in_vld,
  input logic [W-1:0] p1_out,
  input logic         p1_drv,
  input logic [W-1:0] p2_in,
  input logic         p2_in_vld,
  input logic [W-1:0] p2_out,
  input logic         p2_drv,
  input logic         le_a_to_p1,
  input logic         le_a_to_p2,
  input logic         le_p1_to_a,
  input logic         le_p2_to_a,
  input logic         sel_p1,
  input logic         oe_a_n,
  input logic         oe_p1_n,
  input logic         oe_p2_n
);
  assert_follow_p1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (le_a_to_p1 && a_in_vld) |-> (p1_out == a_in));

  assert_return_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_p1_to_a && le_p2_to_a && p1_in_vld && p2_in_vld)
      |-> (a_out == (sel_p1 ? p1_in : p2_in)));

  assert_hold_p2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_a_to_p2 && $past(!le_a_to_p2)) |-> $stable(p2_out));

  assert_oe_p1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_p1_n |-> !p1_drv);

  assert_oe_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_a_n |-> a_drv);

  assert_keeper_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_in_vld && $past(a_in_vld) && le_a_to_p1) |-> (p1_out == $past(a_in)));
endmodule

bind xbar_exchanger xbar_exchanger_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_in(a_in), .a_in_vld(a_in_vld), .a_out(a_out), .a_drv(a_drv),
  .p1_in(p1_in), .p1_in_vld(p1_in_vld), .p1_out(p1_out), .p1_drv(p1_drv),
  .p2_in(p2_in), .p2_in_vld(p2_in_vld), .p2_out(p2_out), .p2_drv(p2_drv),
  .le_a_to_p1(le_a_to_p1), .le_a_to_p2(le_a_to_p2),
  .le_p1_to_a(le_p1_to_a), .le_p2_to_a(le_p2_to_a),
  .sel_p1(sel_p1), .oe_a_n(oe_a_n), .oe_p1_n(oe_p1_n), .oe_p2_n(oe_p2_n)
);

// File: tb/sim_xbar_exchanger.sv
`timescale 1ns/1ps
module sim_xbar_exchanger;
  localparam int W = 12;
  localparam int NV = 16;

  typedef struct packed {
    logic [11:0] a, p1, p2;
    logic [2:0]  vld;   // {a, p1, p2}
    logic [3:0]  le;    // {a_to_p1, a_to_p2, p1_to_a, p2_to_a}
    logic        sel;
    logic [2:0]  oe;    // {a, p1, p2} active low
    logic [11:0] ea, ep1, ep2;
    logic [2:0]  edrv;  // {a_drv, p1_drv, p2_drv}
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{12'h000,12'h000,12'h000,3'b000,4'b0000,1'b1,3'b111,12'h000,12'h000,12'h000,3'b000},
    '{12'h123,12'h000,12'h000,3'b100,4'b1000,1'b1,3'b000,12'h000,12'h123,12'h000,3'b111},
    '{12'h456,12'h000,12'h000,3'b100,4'b0100,1'b1,3'b000,12'h000,12'h123,12'h456,3'b111},
    '{12'h789,12'h000,12'h000,3'b100,4'b0000,1'b1,3'b000,12'h000,12'h123,12'h456,3'b111},
    '{12'hABC,12'h000,12'h000,3'b100,4'b1100,1'b1,3'b000,12'h000,12'hABC,12'hABC,3'b111},
    '{12'h000,12'h000,12'h000,3'b100,4'b0000,1'b1,3'b000,12'h000,12'hABC,12'hABC,3'b111},
    '{12'h000,12'h111,12'h222,3'b111,4'b0011,1'b1,3'b011,12'h111,12'hABC,12'hABC,3'b100},
    '{12'h000,12'h111,12'h222,3'b111,4'b0011,1'b0,3'b001,12'h222,12'hABC,12'hABC,3'b110},
    '{12'h000,12'h333,12'h444,3'b111,4'b0000,1'b1,3'b010,12'h111,12'hABC,12'hABC,3'b101},
    '{12'h000,12'h333,12'h444,3'b111,4'b0000,1'b0,3'b100,12'h222,12'hABC,12'hABC,3'b011},
    '{12'h5A5,12'h000,12'h000,3'b111,4'b1000,1'b0,3'b000,12'h222,12'h5A5,12'hABC,3'b111},
    '{12'hFFF,12'h000,12'h000,3'b011,4'b1000,1'b0,3'b000,12'h222,12'h5A5,12'hABC,3'b111},
    '{12'h0F0,12'h000,12'h000,3'b011,4'b0000,1'b0,3'b000,12'h222,12'h5A5,12'hABC,3'b111},
    '{12'h0F0,12'h0CC,12'h000,3'b011,4'b0010,1'b1,3'b000,12'h0CC,12'h5A5,12'hABC,3'b111},
    '{12'h0F0,12'h777,12'h000,3'b001,4'b0010,1'b1,3'b000,12'h0CC,12'h5A5,12'hABC,3'b111},
    '{12'h0F0,12'h777,12'h000,3'b001,4'b0000,1'b0,3'b000,12'h222,12'h5A5,12'hABC,3'b111}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R9";   1: return "R1";   2: return "R10";  3: return "R3";
      4: return "R7";   5: return "R7";   6: return "R2";   7: return "R4";
      8: return "R3";   9: return "R4";  10: return "R1";  11: return "R8";
      12: return "R8"; 13: return "R2";  14: return "R8";  default: return "R4";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a_in, p1_in, p2_in, a_out, p1_out, p2_out;
  logic a_in_vld, p1_in_vld, p2_in_vld, a_drv, p1_drv, p2_drv;
  logic le_a_to_p1, le_a_to_p2, le_p1_to_a, le_p2_to_a, sel_p1;
  logic oe_a_n, oe_p1_n, oe_p2_n;
  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  xbar_exchanger #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .a_out(a_out), .a_drv(a_drv),
    .p1_in(p1_in), .p1_in_vld(p1_in_vld), .p1_out(p1_out), .p1_drv(p1_drv),
    .p2_in(p2_in), .p2_in_vld(p2_in_vld), .p2_out(p2_out), .p2_drv(p2_drv),
    .le_a_to_p1(le_a_to_p1), .le_a_to_p2(le_a_to_p2),
    .le_p1_to_a(le_p1_to_a), .le_p2_to_a(le_p2_to_a),
    .sel_p1(sel_p1), .oe_a_n(oe_a_n), .oe_p1_n(oe_p1_n), .oe_p2_n(oe_p2_n)
  );

  task automatic chk(string req, string what, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    a_in = v.a; p1_in = v.p1; p2_in = v.p2;
    {a_in_vld, p1_in_vld, p2_in_vld} = v.vld;
    {le_a_to_p1, le_a_to_p2, le_p1_to_a, le_p2_to_a} = v.le;
    sel_p1 = v.sel;
    {oe_a_n, oe_p1_n, oe_p2_n} = v.oe;
  endtask

  initial begin
    rst_n = 1'b0;
    apply(TBL[0]);
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "a_out in reset", a_out, 12'h000);
    chk("R9", "p1_out in reset", p1_out, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      #1;
      chk(tag_of(i), $sformatf("vec%0d a_out", i), a_out, TBL[i].ea);
      chk(tag_of(i), $sformatf("vec%0d p1_out", i), p1_out, TBL[i].ep1);
      chk(tag_of(i), $sformatf("vec%0d p2_out", i), p2_out, TBL[i].ep2);
      chk((i == 8 || i == 9) ? "R6" : "R5", $sformatf("vec%0d drv", i),
          {9'd0, a_drv, p1_drv, p2_drv}, {9'd0, TBL[i].edrv});
    end
    // R9: asynchronous reset mid-run clears held state
    @(negedge clk);
    le_a_to_p1 = 1'b0; le_a_to_p2 = 1'b0; le_p1_to_a = 1'b0; le_p2_to_a = 1'b0;
    #1 rst_n = 1'b0;
    #0.5;
    chk("R9", "p1_out async reset", p1_out, 12'h000);
    chk("R9", "p2_out async reset", p2_out, 12'h000);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sel_p1 = 1'b1; #1;
    chk("R9", "a_out after reset", a_out, 12'h000);
    // R8: keeper of P2 cleared by reset, then retains a fresh value
    @(negedge clk);
    p2_in = 12'h3C3; p2_in_vld = 1'b1; le_p2_to_a = 1'b1; sel_p1 = 1'b0;
    @(negedge clk);
    p2_in = 12'hE0E; p2_in_vld = 1'b0; #1;
    chk("R8", "P2 keeper retained", a_out, 12'h3C3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule